// File: doc/BRIEF.md
# Nibble-Wide Link Transmitter

This block sends packets over a narrow point-to-point link. It accepts 32-bit words from a transmit buffer over a ready/valid interface. It breaks each word into bytes and each byte into two 4-bit nibbles. It drives the nibbles onto a 4-bit bus together with a forwarded clock, which it derives from the core clock through a programmable divisor. Every transition of the forwarded clock, rising or falling, carries one nibble.

The far end throttles the flow through an acknowledge input. A byte that has started always finishes. Before the next byte starts, the transmitter waits for acknowledge and holds the forwarded clock low. Three settings are captured when a packet's first word is accepted: the packet length (one word or four words), the half-period divisor, and whether a checksum byte follows the data. A one-cycle strobe marks the last nibble of each block.

Top module: `link_tx`

## Requirements
- R1: After reset, `lnk_clk` is 0, `lnk_dat` is 0, `blk_done` is 0 and `in_ready` is 1.
- R2: Each byte goes out as its bits [3:0] on the rising edge of `lnk_clk` and its bits [7:4] on the following falling edge. The bytes of a word leave in order from bits [7:0] up to bits [31:24], and `lnk_dat` changes only together with `lnk_clk`.
- R3: With `cfg_large` = 0 a packet is one word (4 bytes). With `cfg_large` = 1 it is four words (16 bytes), taken in order of acceptance.
- R4: With `cfg_cks_en` = 1, one extra byte follows the data: the sum modulo 256 of all data bytes of the packet. With `cfg_cks_en` = 0, no extra byte is sent.
- R5: Each high phase of `lnk_clk` lasts exactly `cfg_speed`+1 core cycles.
- R6: A new byte starts only while `ack_in` is 1. A byte already in flight completes. While `ack_in` stays 0 at a byte boundary, `lnk_clk` stays low and `lnk_dat` does not change.
- R7: `blk_done` is a one-cycle pulse. It occurs exactly once per packet, in the same cycle as the packet's last falling edge of `lnk_clk`.
- R8: `in_ready` is 1 only when idle or when the next word of the packet is needed. It is never 1 while `lnk_clk` is high.
- R9: Changes to `cfg_large`, `cfg_cks_en` and `cfg_speed` after a packet's first word is accepted have no effect on that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_large | input | 1 | Packet length: 0 = 4 bytes, 1 = 16 bytes |
| cfg_cks_en | input | 1 | Append a checksum byte |
| cfg_speed | input | SPD_W | Half-period of `lnk_clk` minus one, in core cycles |
| in_valid | input | 1 | Transmit word is valid |
| in_ready | output | 1 | Transmitter can take a word |
| in_data | input | DATA_W | Transmit word |
| ack_in | input | 1 | Receiver allows another byte |
| lnk_clk | output | 1 | Forwarded link clock |
| lnk_dat | output | 4 | Link nibble bus |
| blk_done | output | 1 | Last nibble of a block is on the bus |

## Verification
If the byte index or the word counter is wrong, the very next packet shows up at the ports with a changed nibble count, reordered bytes, or a `blk_done` that does not line up with the final falling edge. A stale checksum accumulator shows up as a wrong trailing byte in the same packet. A fault in the divider changes the length of the first high phase, so it appears within one byte. A fault in the acknowledge path produces link-clock edges during a hold window, which are visible within a few cycles of the hold starting.

// File: rtl/link_tx_pkg.sv
package link_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_LO,
    ST_HI,
    ST_FETCH
  } tx_state_t;

endpackage

// File: rtl/link_tx_div.sv
module link_tx_div #(
  parameter int SPD_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SPD_W-1:0] limit,
  output logic             tick
);

  logic [SPD_W-1:0] cnt;

  assign tick = run && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= limit)); // R5

endmodule

// File: rtl/link_tx_bytesel.sv
module link_tx_bytesel #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]              word,
  input  logic [$clog2(DATA_W/8)-1:0]    idx,
  output logic [7:0]                     lane
);

  localparam int NB = DATA_W / 8;

  logic [7:0] lanes [NB];

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lanes[g] = word[g*8 +: 8];
  end

  assign lane = lanes[idx];

endmodule

// File: rtl/link_tx_cksum.sv
module link_tx_cksum (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       add,
  input  logic [7:0] byte_in,
  output logic [7:0] sum
);

  always_ff @(posedge clk) begin
    if (rst || clr) sum <= '0;
    else if (add)   sum <= sum + byte_in;
  end

endmodule

// File: rtl/link_tx.sv
module link_tx
  import link_tx_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SPD_W       = 4,
  parameter int SMALL_BYTES = 4,
  parameter int LARGE_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_large,
  input  logic              cfg_cks_en,
  input  logic [SPD_W-1:0]  cfg_speed,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              ack_in,
  output logic              lnk_clk,
  output logic [3:0]        lnk_dat,
  output logic              blk_done
);

  localparam int BPW         = DATA_W / 8;
  localparam int IDX_W       = $clog2(BPW);
  localparam int SMALL_WORDS = SMALL_BYTES / BPW;
  localparam int LARGE_WORDS = LARGE_BYTES / BPW;
  localparam int WC_W        = $clog2(LARGE_WORDS + 1);

  tx_state_t         st;
  logic [DATA_W-1:0] wbuf;
  logic [IDX_W-1:0]  bidx;
  logic [WC_W-1:0]   words_left;
  logic [SPD_W-1:0]  spd_q;
  logic              cks_q;
  logic              cks_phase;

  logic              accept;
  logic              tick;
  logic              run;
  logic              byte_end;
  logic              last_in_word;
  logic [7:0]        lane;
  logic [7:0]        sum;
  logic [7:0]        byte_cur;

  assign in_ready     = (st == ST_IDLE) || (st == ST_FETCH);
  assign accept       = in_valid && in_ready;
  assign run          = (st == ST_LO) || (st == ST_HI);
  assign byte_end     = (st == ST_HI) && tick;
  assign last_in_word = (bidx == IDX_W'(BPW - 1));
  assign byte_cur     = cks_phase ? sum : lane;

  link_tx_div #(.SPD_W(SPD_W)) u_div (
    .clk   (clk),
    .rst   (rst),
    .run   (run),
    .limit (spd_q),
    .tick  (tick)
  );

  link_tx_bytesel #(.DATA_W(DATA_W)) u_sel (
    .word (wbuf),
    .idx  (bidx),
    .lane (lane)
  );

  link_tx_cksum u_cks (
    .clk     (clk),
    .rst     (rst),
    .clr     (accept && (st == ST_IDLE)),
    .add     (byte_end && !cks_phase),
    .byte_in (lane),
    .sum     (sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      wbuf       <= '0;
      bidx       <= '0;
      words_left <= '0;
      spd_q      <= '0;
      cks_q      <= 1'b0;
      cks_phase  <= 1'b0;
      lnk_clk    <= 1'b0;
      lnk_dat    <= '0;
      blk_done   <= 1'b0;
    end else begin
      blk_done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            wbuf       <= in_data;
            bidx       <= '0;
            words_left <= cfg_large ? WC_W'(LARGE_WORDS - 1) : WC_W'(SMALL_WORDS - 1);
            spd_q      <= cfg_speed;
            cks_q      <= cfg_cks_en;
            cks_phase  <= 1'b0;
            st         <= ST_WAIT;
          end
        end
        ST_FETCH: begin
          if (accept) begin
            wbuf       <= in_data;
            bidx       <= '0;
            words_left <= words_left - 1'b1;
            st         <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (ack_in) st <= ST_LO;
        end
        ST_LO: begin
          if (tick) begin
            lnk_clk <= 1'b1;
            lnk_dat <= byte_cur[3:0];
            st      <= ST_HI;
          end
        end
        ST_HI: begin
          if (tick) begin
            lnk_clk <= 1'b0;
            lnk_dat <= byte_cur[7:4];
            if (cks_phase) begin
              cks_phase <= 1'b0;
              blk_done  <= 1'b1;
              st        <= ST_IDLE;
            end else if (!last_in_word) begin
              bidx <= bidx + 1'b1;
              st   <= ST_WAIT;
            end else if (words_left != '0) begin
              st <= ST_FETCH;
            end else if (cks_q) begin
              cks_phase <= 1'b1;
              st        <= ST_WAIT;
            end else begin
              blk_done <= 1'b1;
              st       <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_READY_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !lnk_clk); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    blk_done |=> !blk_done); // R7

  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    blk_done |-> $fell(lnk_clk)); // R7

  AST_DAT_WITH_CLK: assert property (@(posedge clk) disable iff (rst)
    $stable(lnk_clk) |-> $stable(lnk_dat)); // R2

  AST_HOLD_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT && !ack_in) |=> (!lnk_clk && $stable(lnk_dat))); // R6

endmodule

// File: tb/sim_link_tx.sv
module sim_link_tx;

  localparam int NV = 4;
  // {large, cks_en, speed[3:0], w3, w2, w1, w0}
  localparam logic [133:0] VEC [NV] = '{
    {1'b0, 1'b0, 4'd0, 96'h0, 32'hA1B2C3D4},
    {1'b0, 1'b1, 4'd3, 96'h0, 32'h0F1E2D3C},
    {1'b1, 1'b1, 4'd1, 32'hDDEEFF00, 32'h99AABBCC, 32'h55667788, 32'h11223344},
    {1'b1, 1'b0, 4'd2, 32'hCAFEF00D, 32'h12345678, 32'h80000001, 32'hFFFFFFFF}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_large = 1'b0;
  logic        cfg_cks_en = 1'b0;
  logic [3:0]  cfg_speed = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        ack_in = 1'b1;
  logic        lnk_clk;
  logic [3:0]  lnk_dat;
  logic        blk_done;

  always #5 clk = ~clk;

  link_tx u0 (
    .clk(clk), .rst(rst), .cfg_large(cfg_large), .cfg_cks_en(cfg_cks_en),
    .cfg_speed(cfg_speed), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .ack_in(ack_in), .lnk_clk(lnk_clk),
    .lnk_dat(lnk_dat), .blk_done(blk_done)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  int cyc = 0;
  logic prev_clk = 1'b0;
  logic [3:0] nibs [0:2047];
  int nib_cnt = 0, done_cnt = 0, rise_cyc = 0, hi_len = 0;
  int last_fall_cyc = -1, done_cyc = -2;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst) begin
      prev_clk = 1'b0;
    end else begin
      if (lnk_clk !== prev_clk) begin
        nibs[nib_cnt] = lnk_dat;
        nib_cnt = nib_cnt + 1;
        if (lnk_clk) rise_cyc = cyc;
        else begin
          hi_len = cyc - rise_cyc;
          last_fall_cyc = cyc;
        end
      end
      prev_clk = lnk_clk;
      if (blk_done) begin
        done_cnt = done_cnt + 1;
        done_cyc = cyc;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_word(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_done(input int base_d);
    for (int t = 0; t < 3000 && done_cnt <= base_d; t++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // compares captured stream with expectation
  task automatic check_stream(input int base_n, input int base_d, input int nw,
                              input bit cks, input int spd, input logic [127:0] ws);
    logic [7:0] b;
    logic [7:0] s;
    int nb;
    int bad;
    nb = nw * 4;
    s = 8'h00;
    bad = 0;
    check(nib_cnt - base_n == 2 * (nb + (cks ? 1 : 0)), "R3 R4 nibble count",
          nib_cnt - base_n, 2 * (nb + (cks ? 1 : 0)));
    for (int k = 0; k < nb; k++) begin
      b = ws[k*8 +: 8];
      s = s + b;
      if (nibs[base_n + 2*k] !== b[3:0] || nibs[base_n + 2*k + 1] !== b[7:4]) bad++;
    end
    check(bad == 0, "R2 R3 data nibble order", bad, 0);
    if (cks)
      check({nibs[base_n + 2*nb + 1], nibs[base_n + 2*nb]} == s, "R4 checksum byte",
            {nibs[base_n + 2*nb + 1], nibs[base_n + 2*nb]}, s);
    check(done_cnt - base_d == 1, "R7 one done pulse", done_cnt - base_d, 1);
    check(done_cyc == last_fall_cyc, "R7 done on last fall", done_cyc, last_fall_cyc);
    check(hi_len == spd + 1, "R5 high phase length", hi_len, spd + 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : main
    int bn, bd;
    logic [127:0] ws;
    repeat (3) @(negedge clk);
    check(lnk_clk == 1'b0 && lnk_dat == 4'h0 && blk_done == 1'b0, "R1 outputs in reset",
          {lnk_clk, lnk_dat, blk_done}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
    check(lnk_clk == 1'b0 && lnk_dat == 4'h0, "R1 link idle", {lnk_clk, lnk_dat}, 0);

    for (int v = 0; v < NV; v++) begin
      cfg_large  = VEC[v][133];
      cfg_cks_en = VEC[v][132];
      cfg_speed  = VEC[v][131:128];
      bn = nib_cnt;
      bd = done_cnt;
      for (int w = 0; w < (VEC[v][133] ? 4 : 1); w++) send_word(VEC[v][w*32 +: 32]);
      wait_done(bd);
      check_stream(bn, bd, VEC[v][133] ? 4 : 1, VEC[v][132], int'(VEC[v][131:128]),
                   VEC[v][127:0]);
    end

    // R6: acknowledge low before the first byte
    cfg_large = 1'b0; cfg_cks_en = 1'b0; cfg_speed = 4'd1;
    ack_in = 1'b0;
    bn = nib_cnt; bd = done_cnt;
    send_word(32'h5A6B7C8D);
    repeat (20) @(negedge clk);
    check(nib_cnt == bn, "R6 no edges without ack", nib_cnt - bn, 0);
    check(in_ready == 1'b0, "R8 not ready while word pending", in_ready, 0);
    ack_in = 1'b1;
    wait_done(bd);
    ws = {96'h0, 32'h5A6B7C8D};
    check_stream(bn, bd, 1, 1'b0, 1, ws);

    // R6: acknowledge dropped in the middle of a byte
    cfg_speed = 4'd2;
    bn = nib_cnt; bd = done_cnt;
    send_word(32'h76543210);
    wait (nib_cnt == bn + 3);
    @(negedge clk);
    ack_in = 1'b0;
    repeat (30) @(negedge clk);
    check(nib_cnt == bn + 4, "R6 byte in flight completes then holds", nib_cnt - bn, 4);
    check(lnk_clk == 1'b0, "R6 clock held low", lnk_clk, 0);
    check(in_ready == 1'b0, "R8 not ready during hold", in_ready, 0);
    ack_in = 1'b1;
    wait_done(bd);
    ws = {96'h0, 32'h76543210};
    check_stream(bn, bd, 1, 1'b0, 2, ws);

    // R9: settings changed after the first word is taken
    cfg_large = 1'b0; cfg_cks_en = 1'b0; cfg_speed = 4'd0;
    bn = nib_cnt; bd = done_cnt;
    send_word(32'h0BADCAFE);
    cfg_large = 1'b1; cfg_cks_en = 1'b1; cfg_speed = 4'd5;
    wait_done(bd);
    ws = {96'h0, 32'h0BADCAFE};
    check(nib_cnt - bn == 8, "R9 length unchanged", nib_cnt - bn, 8);
    check(hi_len == 1, "R9 speed unchanged", hi_len, 1);
    check(in_ready == 1'b1, "R8 ready when idle", in_ready, 1);
    check_stream(bn, bd, 1, 1'b0, 0, ws);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule